// File: doc/BRIEF.md
# Register Renaming Unit with Checkpoints

This block sits between decode and scheduling in an out-of-order core. Each cycle it takes a group of up to four decoded instructions and rewrites their architectural register numbers into physical register tags. Sources are read from a map table. Every destination receives a fresh tag from a pool of free physical registers. Because each write gets a new physical home, write-after-write and write-after-read conflicts between in-flight instructions vanish, and only true data flow remains.

Each renamed instruction also reports the tag its destination register held before the rename. The retire logic hands that tag back through the retire ports once the instruction leaves the machine in program order. Every accepted group is stamped with a checkpoint number, and the map as it stood just before that group is saved under that number. A recover request naming a checkpoint rolls the map back to that snapshot. It also returns to the pool every tag that was allocated from that group onward. When the pool cannot cover a group, the stall output rises and the group is refused as a whole.

Top module: `reg_rename`

## Requirements
- R1: After reset, architectural register i reads as physical tag i, the pool holds exactly tags 32 to 79, and the checkpoint number is 0.
- R2: A source with no older same-group writer returns the map table entry for its architectural register.
- R3: Each valid slot of an accepted group receives a distinct tag taken from the pool. Slots are served from slot 0 upward, and each takes the lowest-numbered free tag still left. Invalid slots take nothing, and after the edge the map points each written architectural register at the tag of its youngest writer.
- R4: The previous-tag output of a slot is the mapping of its destination just before that slot: either the map table entry or, when an older slot in the same group writes the same register, that slot's new tag.
- R5: A source matching an older slot's destination in the same group takes the new tag of the youngest such older slot.
- R6: When the pool holds fewer tags than the group has valid slots, stall is high and neither the map, the pool nor the checkpoint number changes.
- R7: A tag presented on a valid retire port is back in the pool from the next cycle and can be handed out again.
- R8: The checkpoint number output names the current group. It starts at 0 and advances by one, wrapping modulo 8, after each accepted group.
- R9: A recover request for checkpoint c restores the map saved for group c, returns to the pool every tag allocated from group c onward, and sets the checkpoint number to c.
- R10: A recover request wins over a rename group in the same cycle: stall is high and the group leaves no trace.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 4 | Per-slot valid, slot 0 oldest |
| in_src_a | input | 20 | First source register, 5 bits per slot, slot k at bits 5k+4:5k |
| in_src_b | input | 20 | Second source register, same packing |
| in_dst | input | 20 | Destination register, same packing |
| out_src_a | output | 28 | Physical tag of first source, 7 bits per slot, slot k at bits 7k+6:7k |
| out_src_b | output | 28 | Physical tag of second source, same packing |
| out_dst | output | 28 | Newly allocated destination tag, same packing |
| out_prev | output | 28 | Previous tag of the destination, same packing |
| out_ckpt | output | 3 | Checkpoint number of the current group |
| stall | output | 1 | Group refused this cycle |
| ret_valid | input | 4 | Per-port retire valid |
| ret_tag | input | 28 | Tags returned to the pool, 7 bits per port |
| rec_valid | input | 1 | Recover request |
| rec_ckpt | input | 3 | Checkpoint to roll back to |

## Verification
A full group whose slots chain through each other's destinations separates a table lookup from the same-group bypass. It also separates the previous tag taken from the table from the one taken from an older slot. A group with holes in its valid mask shows that invalid slots take no tag and do not disturb the lowest-first order. Draining the pool down to one tag and then offering two writers tells a clean refusal apart from a partial allocation: the single later writer must get the last tag and see the old mapping. Two nested rollbacks, the first issued together with a rename group, show both the restored map and the reclaimed tags through the next allocations.

// File: rtl/rr_pkg.sv
package rr_pkg;
  localparam int RR_ARCH  = 32;
  localparam int RR_PHYS  = 80;
  localparam int RR_LANES = 4;
  localparam int RR_CKPTS = 8;
endpackage

// File: rtl/rr_free_pool.sv
module rr_free_pool #(
  parameter int NPHYS = rr_pkg::RR_PHYS,
  parameter int NARCH = rr_pkg::RR_ARCH,
  parameter int LANES = rr_pkg::RR_LANES,
  parameter int NCKPT = rr_pkg::RR_CKPTS,
  localparam int PW  = $clog2(NPHYS),
  localparam int CW  = $clog2(NCKPT),
  localparam int FCW = $clog2(NPHYS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [LANES-1:0]    req_valid,
  input  logic                commit,
  input  logic [CW-1:0]       ckpt_ptr,
  input  logic [LANES-1:0]    ret_valid,
  input  logic [LANES*PW-1:0] ret_tag,
  input  logic                rec_valid,
  input  logic [CW-1:0]       rec_ckpt,
  output logic [LANES*PW-1:0] grant,
  output logic [FCW-1:0]      free_count,
  output logic                short_of_tags,
  output logic [NPHYS-1:0]    free_vec
);

  function automatic logic [NPHYS-1:0] reset_pool();
    logic [NPHYS-1:0] v;
    v = '0;
    for (int i = 0; i < NPHYS; i++) if (i >= NARCH) v[i] = 1'b1;
    return v;
  endfunction

  function automatic logic [PW-1:0] lowest_free(input logic [NPHYS-1:0] v);
    logic [PW-1:0] idx;
    idx = '0;
    for (int i = NPHYS - 1; i >= 0; i--) if (v[i]) idx = PW'(i);
    return idx;
  endfunction

  logic [NPHYS-1:0] free_q, avail, alloc_mask, next_free;
  logic [NPHYS-1:0] ckm_q [NCKPT];
  logic [FCW-1:0]   need;

  always_comb begin
    avail = free_q;
    grant = '0;
    for (int k = 0; k < LANES; k++) begin
      if (req_valid[k]) begin
        grant[k*PW +: PW] = lowest_free(avail);
        avail[lowest_free(avail)] = 1'b0;
      end
    end
    alloc_mask = free_q & ~avail;
  end

  assign free_count    = FCW'($countones(free_q));
  assign need          = FCW'($countones(req_valid));
  assign short_of_tags = need > free_count;
  assign free_vec      = free_q;

  always_comb begin
    next_free = free_q;
    if (commit) next_free = next_free & ~alloc_mask;
    for (int j = 0; j < LANES; j++)
      if (ret_valid[j]) next_free[ret_tag[j*PW +: PW]] = 1'b1;
    if (rec_valid) next_free = next_free | ckm_q[rec_ckpt];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      free_q <= reset_pool();
      for (int c = 0; c < NCKPT; c++) ckm_q[c] <= '0;
    end else begin
      free_q <= next_free;
      if (commit) begin
        for (int c = 0; c < NCKPT; c++)
          ckm_q[c] <= (CW'(c) == ckpt_ptr) ? alloc_mask : (ckm_q[c] | alloc_mask);
      end
    end
  end

endmodule

// File: rtl/rr_map_table.sv
module rr_map_table #(
  parameter int NPHYS = rr_pkg::RR_PHYS,
  parameter int NARCH = rr_pkg::RR_ARCH,
  parameter int LANES = rr_pkg::RR_LANES,
  parameter int NCKPT = rr_pkg::RR_CKPTS,
  localparam int PW = $clog2(NPHYS),
  localparam int AW = $clog2(NARCH),
  localparam int CW = $clog2(NCKPT)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [LANES-1:0]    in_valid,
  input  logic [LANES*AW-1:0] src_a,
  input  logic [LANES*AW-1:0] src_b,
  input  logic [LANES*AW-1:0] dst,
  input  logic [LANES*PW-1:0] grant,
  input  logic                commit,
  input  logic [CW-1:0]       ckpt_ptr,
  input  logic                rec_valid,
  input  logic [CW-1:0]       rec_ckpt,
  output logic [LANES*PW-1:0] psrc_a,
  output logic [LANES*PW-1:0] psrc_b,
  output logic [LANES*PW-1:0] pprev
);

  logic [PW-1:0] map_q  [NARCH];
  logic [PW-1:0] next_map [NARCH];
  logic [PW-1:0] snap_q [NCKPT][NARCH];

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      psrc_a[k*PW +: PW] = map_q[src_a[k*AW +: AW]];
      psrc_b[k*PW +: PW] = map_q[src_b[k*AW +: AW]];
      pprev[k*PW +: PW]  = map_q[dst[k*AW +: AW]];
      for (int j = 0; j < k; j++) begin
        if (in_valid[j] && dst[j*AW +: AW] == src_a[k*AW +: AW]) psrc_a[k*PW +: PW] = grant[j*PW +: PW];
        if (in_valid[j] && dst[j*AW +: AW] == src_b[k*AW +: AW]) psrc_b[k*PW +: PW] = grant[j*PW +: PW];
        if (in_valid[j] && dst[j*AW +: AW] == dst[k*AW +: AW])   pprev[k*PW +: PW]  = grant[j*PW +: PW];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NARCH; i++) next_map[i] = map_q[i];
    for (int k = 0; k < LANES; k++)
      if (in_valid[k]) next_map[dst[k*AW +: AW]] = grant[k*PW +: PW];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NARCH; i++) map_q[i] <= PW'(i);
    end else if (rec_valid) begin
      for (int i = 0; i < NARCH; i++) map_q[i] <= snap_q[rec_ckpt][i];
    end else if (commit) begin
      for (int i = 0; i < NARCH; i++) begin
        map_q[i] <= next_map[i];
        snap_q[ckpt_ptr][i] <= map_q[i];
      end
    end
  end

endmodule

// File: rtl/reg_rename.sv
module reg_rename #(
  parameter int NARCH = rr_pkg::RR_ARCH,
  parameter int NPHYS = rr_pkg::RR_PHYS,
  parameter int LANES = rr_pkg::RR_LANES,
  parameter int NCKPT = rr_pkg::RR_CKPTS,
  localparam int AW = $clog2(NARCH),
  localparam int PW = $clog2(NPHYS),
  localparam int CW = $clog2(NCKPT)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [LANES-1:0]    in_valid,
  input  logic [LANES*AW-1:0] in_src_a,
  input  logic [LANES*AW-1:0] in_src_b,
  input  logic [LANES*AW-1:0] in_dst,
  output logic [LANES*PW-1:0] out_src_a,
  output logic [LANES*PW-1:0] out_src_b,
  output logic [LANES*PW-1:0] out_dst,
  output logic [LANES*PW-1:0] out_prev,
  output logic [CW-1:0]       out_ckpt,
  output logic                stall,
  input  logic [LANES-1:0]    ret_valid,
  input  logic [LANES*PW-1:0] ret_tag,
  input  logic                rec_valid,
  input  logic [CW-1:0]       rec_ckpt
);

  localparam int FCW = $clog2(NPHYS + 1);

  logic [CW-1:0]    ckpt_ptr;
  logic             fire;
  logic             short_of_tags;
  logic [FCW-1:0]   free_count;
  logic [NPHYS-1:0] free_vec;

  assign fire     = (|in_valid) && !short_of_tags && !rec_valid;
  assign stall    = rec_valid || ((|in_valid) && short_of_tags);
  assign out_ckpt = ckpt_ptr;

  rr_free_pool #(.NPHYS(NPHYS), .NARCH(NARCH), .LANES(LANES), .NCKPT(NCKPT)) pool (
    .clk(clk), .rst(rst), .req_valid(in_valid), .commit(fire), .ckpt_ptr(ckpt_ptr),
    .ret_valid(ret_valid), .ret_tag(ret_tag), .rec_valid(rec_valid), .rec_ckpt(rec_ckpt),
    .grant(out_dst), .free_count(free_count), .short_of_tags(short_of_tags), .free_vec(free_vec)
  );

  rr_map_table #(.NPHYS(NPHYS), .NARCH(NARCH), .LANES(LANES), .NCKPT(NCKPT)) table_u (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src_a(in_src_a), .src_b(in_src_b),
    .dst(in_dst), .grant(out_dst), .commit(fire), .ckpt_ptr(ckpt_ptr),
    .rec_valid(rec_valid), .rec_ckpt(rec_ckpt),
    .psrc_a(out_src_a), .psrc_b(out_src_b), .pprev(out_prev)
  );

  always_ff @(posedge clk) begin
    if (rst)            ckpt_ptr <= '0;
    else if (rec_valid) ckpt_ptr <= rec_ckpt;
    else if (fire)      ckpt_ptr <= (int'(ckpt_ptr) == NCKPT - 1) ? '0 : ckpt_ptr + 1'b1;
  end

endmodule

// File: rtl/rr_checker.sv
module rr_checker #(
  parameter int NARCH = 32,
  parameter int NPHYS = 80,
  parameter int LANES = 4,
  parameter int NCKPT = 8,
  localparam int AW  = $clog2(NARCH),
  localparam int PW  = $clog2(NPHYS),
  localparam int CW  = $clog2(NCKPT),
  localparam int FCW = $clog2(NPHYS + 1)
) (
  input logic                clk,
  input logic                rst,
  input logic [LANES-1:0]    in_valid,
  input logic [LANES*AW-1:0] in_src_a,
  input logic [LANES*AW-1:0] in_dst,
  input logic [LANES*PW-1:0] out_src_a,
  input logic [LANES*PW-1:0] out_dst,
  input logic [CW-1:0]       out_ckpt,
  input logic                stall,
  input logic                fire,
  input logic [FCW-1:0]      free_count,
  input logic [NPHYS-1:0]    free_vec,
  input logic [LANES-1:0]    ret_valid,
  input logic                rec_valid,
  input logic [CW-1:0]       rec_ckpt
);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assert_grant_free_R3: assert property (@(posedge clk) disable iff (rst)
      fire && in_valid[k] |-> free_vec[out_dst[k*PW +: PW]]);
    for (genvar j = 0; j < k; j++) begin : g_pair
      assert_distinct_R3: assert property (@(posedge clk) disable iff (rst)
        fire && in_valid[j] && in_valid[k] |-> out_dst[j*PW +: PW] != out_dst[k*PW +: PW]);
    end
    if (k > 0) begin : g_byp
      assert_bypass_R5: assert property (@(posedge clk) disable iff (rst)
        fire && in_valid[k-1] && in_valid[k] && in_src_a[k*AW +: AW] == in_dst[(k-1)*AW +: AW]
        |-> out_src_a[k*PW +: PW] == out_dst[(k-1)*PW +: PW]);
    end
  end

  assert_shortage_R6: assert property (@(posedge clk) disable iff (rst)
    (|in_valid) && int'(free_count) < $countones(in_valid) |-> stall);

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    stall && !rec_valid && ret_valid == '0 |=> free_count == $past(free_count));

  assert_consume_R3: assert property (@(posedge clk) disable iff (rst)
    fire && ret_valid == '0 |=> int'(free_count) == int'($past(free_count)) - $countones($past(in_valid)));

  assert_rollback_R9: assert property (@(posedge clk) disable iff (rst)
    rec_valid |=> out_ckpt == $past(rec_ckpt));

  assert_no_fire_R10: assert property (@(posedge clk) disable iff (rst)
    rec_valid |-> stall && !fire);

endmodule

bind reg_rename rr_checker #(.NARCH(NARCH), .NPHYS(NPHYS), .LANES(LANES), .NCKPT(NCKPT)) chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_src_a(in_src_a), .in_dst(in_dst),
  .out_src_a(out_src_a), .out_dst(out_dst), .out_ckpt(out_ckpt), .stall(stall),
  .fire(fire), .free_count(free_count), .free_vec(free_vec), .ret_valid(ret_valid),
  .rec_valid(rec_valid), .rec_ckpt(rec_ckpt)
);

// File: tb/reg_rename_test.sv
`timescale 1ns/1ps
module reg_rename_test;
  localparam int AW = 5;
  localparam int PW = 7;
  localparam int L  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [L-1:0]    in_valid = '0;
  logic [L*AW-1:0] in_src_a = '0, in_src_b = '0, in_dst = '0;
  logic [L*PW-1:0] out_src_a, out_src_b, out_dst, out_prev;
  logic [2:0]      out_ckpt;
  logic            stall;
  logic [L-1:0]    ret_valid = '0;
  logic [L*PW-1:0] ret_tag = '0;
  logic            rec_valid = 1'b0;
  logic [2:0]      rec_ckpt = '0;
  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  reg_rename uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_src_a(in_src_a), .in_src_b(in_src_b),
    .in_dst(in_dst), .out_src_a(out_src_a), .out_src_b(out_src_b), .out_dst(out_dst),
    .out_prev(out_prev), .out_ckpt(out_ckpt), .stall(stall), .ret_valid(ret_valid),
    .ret_tag(ret_tag), .rec_valid(rec_valid), .rec_ckpt(rec_ckpt)
  );

  function automatic int sa(int k); return int'(out_src_a[k*PW +: PW]); endfunction
  function automatic int sb(int k); return int'(out_src_b[k*PW +: PW]); endfunction
  function automatic int nd(int k); return int'(out_dst[k*PW +: PW]);   endfunction
  function automatic int pv(int k); return int'(out_prev[k*PW +: PW]);  endfunction

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic slot(input int k, input int a, input int b, input int d);
    in_valid[k] = 1'b1;
    in_src_a[k*AW +: AW] = AW'(a);
    in_src_b[k*AW +: AW] = AW'(b);
    in_dst[k*AW +: AW]   = AW'(d);
  endtask

  task automatic idle();
    in_valid = '0; ret_valid = '0; rec_valid = 1'b0;
  endtask

  task automatic settle(); #1; endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
    idle();
  endtask

  task automatic do_reset();
    idle();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    for (int k = 0; k < L; k++) slot(k, 2*k, 2*k+1, 10+k);
    settle();
    for (int k = 0; k < L; k++) begin
      check("R1 src_a identity", sa(k), 2*k);
      check("R1 src_b identity", sb(k), 2*k+1);
      check("R1 first tags from 32", nd(k), 32+k);
      check("R4 prev from table", pv(k), 10+k);
    end
    check("R1 ckpt starts 0", int'(out_ckpt), 0);
    check("R1 no stall", int'(stall), 0);
    step();
  endtask

  task automatic t_chain();
    do_reset();
    slot(0, 2, 3, 3); slot(1, 1, 3, 2); slot(2, 3, 1, 1); slot(3, 3, 1, 2);
    settle();
    check("R2 s0 a", sa(0), 2);  check("R2 s0 b", sb(0), 3);
    check("R3 s0 dst", nd(0), 32); check("R4 s0 prev", pv(0), 3);
    check("R2 s1 a", sa(1), 1);  check("R5 s1 b", sb(1), 32);
    check("R3 s1 dst", nd(1), 33); check("R4 s1 prev", pv(1), 2);
    check("R5 s2 a", sa(2), 32); check("R2 s2 b", sb(2), 1);
    check("R4 s2 prev", pv(2), 1);
    check("R5 s3 a", sa(3), 32); check("R5 s3 b", sb(3), 34);
    check("R3 s3 dst", nd(3), 35); check("R4 s3 prev in-group", pv(3), 33);
    step();
    slot(0, 1, 2, 9); slot(1, 3, 0, 8);
    settle();
    check("R3 map r1", sa(0), 34); check("R3 map r2 youngest", sb(0), 35);
    check("R3 map r3", sa(1), 32); check("R3 next dst", nd(0), 36);
    check("R8 ckpt advances", int'(out_ckpt), 1);
    step();
  endtask

  task automatic t_holes();
    do_reset();
    slot(1, 0, 0, 4); slot(3, 4, 0, 5);
    settle();
    check("R3 hole s1 dst", nd(1), 32);
    check("R3 hole s3 dst", nd(3), 33);
    check("R5 across hole", sa(3), 32);
    step();
  endtask

  task automatic t_stall();
    do_reset();
    for (int g = 0; g < 11; g++) begin
      for (int k = 0; k < L; k++) slot(k, 0, 0, k);
      step();
    end
    for (int k = 0; k < 3; k++) slot(k, 0, 0, k);
    settle();
    check("R3 alloc 78", nd(2), 78);
    step();
    slot(0, 20, 20, 20); slot(1, 21, 21, 21);
    settle();
    check("R6 stall on shortage", int'(stall), 1);
    step();
    slot(0, 20, 21, 22);
    settle();
    check("R6 no stall single", int'(stall), 0);
    check("R6 map untouched a", sa(0), 20);
    check("R6 map untouched b", sb(0), 21);
    check("R6 last tag kept", nd(0), 79);
    check("R8 ckpt wrap", int'(out_ckpt), 4);
    step();
    slot(0, 0, 0, 23);
    settle();
    check("R6 empty pool stalls", int'(stall), 1);
    step();
  endtask

  task automatic t_retire();
    do_reset();
    slot(0, 0, 0, 1);
    settle();
    check("R4 prev p1", pv(0), 1);
    step();
    ret_valid[0] = 1'b1; ret_tag[0 +: PW] = 7'd1;
    ret_valid[2] = 1'b1; ret_tag[2*PW +: PW] = 7'd7;
    step();
    slot(0, 0, 0, 2); slot(1, 0, 0, 3); slot(2, 0, 0, 4);
    settle();
    check("R7 reuse p1", nd(0), 1);
    check("R7 reuse p7", nd(1), 7);
    check("R7 then pool", nd(2), 33);
    step();
  endtask

  task automatic t_recover();
    do_reset();
    slot(0, 0, 0, 1);
    step();
    slot(0, 0, 0, 1); slot(1, 0, 0, 2);
    settle();
    check("R8 second ckpt", int'(out_ckpt), 1);
    step();
    rec_valid = 1'b1; rec_ckpt = 3'd1;
    slot(0, 0, 0, 5);
    settle();
    check("R10 stall on recover", int'(stall), 1);
    step();
    slot(0, 1, 2, 3); slot(1, 5, 0, 6);
    settle();
    check("R9 r1 restored", sa(0), 32);
    check("R9 r2 restored", sb(0), 2);
    check("R9 tag reclaimed", nd(0), 33);
    check("R9 prev r3", pv(0), 3);
    check("R10 r5 untouched", sa(1), 5);
    check("R9 next reclaimed", nd(1), 34);
    check("R9 ckpt set", int'(out_ckpt), 1);
    step();
    rec_valid = 1'b1; rec_ckpt = 3'd0;
    step();
    slot(0, 1, 3, 7);
    settle();
    check("R9 deep r1", sa(0), 1);
    check("R9 deep r3", sb(0), 3);
    check("R9 deep reclaim", nd(0), 32);
    check("R9 deep ckpt", int'(out_ckpt), 0);
    step();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_chain();
    t_holes();
    t_stall();
    t_retire();
    t_recover();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule